// File: doc/BRIEF.md
# Two-Slice Unsigned Magnitude Comparator With Output Enable

This block compares two unsigned operands and raises one of three flags: equal, greater-than or less-than. The operand width is split into an upper and a lower slice of equal size. Each slice forms its own three-way result: a per-bit match vector (the complement of the XOR of the two bits), with equality being the AND of that vector and the ordering being decided at the most significant mismatching bit. A merge stage then combines the two slice results into the full-width answer.

In the merge, a difference in the upper slice settles the outcome by itself. Only when the upper slices match does the lower slice's verdict pass through. The full-width equal flag is taken as the case where neither ordering flag is set. An active-high enable forces all three flags low when it is deasserted. The block has no clock and no storage, so its outputs follow its inputs directly. The default is two 4-bit slices, which gives 8-bit operands.

Top module: `mag_cmp8`

## Requirements
- R1: With `en`=1 and `opa` > `opb` as unsigned numbers, `gt_o`=1, `eq_o`=0 and `lt_o`=0.
- R2: With `en`=1 and `opa` < `opb` as unsigned numbers, `lt_o`=1, `eq_o`=0 and `gt_o`=0.
- R3: With `en`=1 and `opa` == `opb`, which requires every bit pair to match, `eq_o`=1, `gt_o`=0 and `lt_o`=0.
- R4: When the upper slices (bits 7:4 at default size) differ, the ordering flag follows the upper slices alone, whatever the lower bits are.
- R5: When the upper slices are equal, the lower slices (bits 3:0 at default size) alone decide `eq_o`, `gt_o` and `lt_o`.
- R6: With `en`=0, `eq_o`, `gt_o` and `lt_o` are all 0 for every operand pair.
- R7: With `en`=1, exactly one of `eq_o`, `gt_o` and `lt_o` is 1 for every operand pair.
- R8: The outputs settle from the inputs combinationally, with no clock edge between an input change and the new result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 8 | First unsigned operand |
| opb | input | 8 | Second unsigned operand |
| en | input | 1 | Output enable, active high |
| eq_o | output | 1 | Operands are equal |
| gt_o | output | 1 | `opa` is greater than `opb` |
| lt_o | output | 1 | `opa` is less than `opb` |

## Verification
Every operand pair is applied with the enable both low and high, and each result is compared against an integer comparison made in the bench. Pairs whose upper nibbles differ but whose lower nibbles order the other way catch a merge that lets the lower slice override the upper; such a design would report the wrong ordering flag. Pairs with equal upper nibbles catch a merge that ignores the lower slice, which would show as a missing flag or as a false equal. Sweeping the enable catches flags that leak through while it is low. A set of input changes checked without any clock edge would expose logic that registered its result, since the outputs would lag the inputs.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    typedef struct packed {
        logic eq;
        logic gt;
        logic lt;
    } cmp_flags_t;

endpackage

// File: rtl/mag_slice.sv
module mag_slice #(
    parameter int W = 4
) (
    input  logic [W-1:0]        a,
    input  logic [W-1:0]        b,
    output cmp_pkg::cmp_flags_t res
);

    logic [W-1:0] bit_match;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_match
            assign bit_match[gi] = ~(a[gi] ^ b[gi]);
        end
    endgenerate

    // scan from the most significant bit; the first mismatch decides
    always_comb begin
        logic above_eq;
        logic gt_v;
        logic lt_v;
        above_eq = 1'b1;
        gt_v     = 1'b0;
        lt_v     = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            gt_v     = gt_v | (above_eq & a[i] & ~b[i]);
            lt_v     = lt_v | (above_eq & ~a[i] & b[i]);
            above_eq = above_eq & bit_match[i];
        end
        res.eq = &bit_match;
        res.gt = gt_v;
        res.lt = lt_v;
    end

endmodule

// File: rtl/mag_merge.sv
module mag_merge (
    input  cmp_pkg::cmp_flags_t hi,
    input  cmp_pkg::cmp_flags_t lo,
    input  logic                en,
    output cmp_pkg::cmp_flags_t res
);

    logic gt_raw;
    logic lt_raw;
    logic eq_raw;

    always_comb begin
        gt_raw = hi.gt | (hi.eq & lo.gt);
        lt_raw = hi.lt | (hi.eq & lo.lt);
        eq_raw = ~gt_raw & ~lt_raw;
        res.eq = en & eq_raw;
        res.gt = en & gt_raw;
        res.lt = en & lt_raw;
    end

endmodule

// File: rtl/mag_cmp8.sv
module mag_cmp8 #(
    parameter int SLICE_W = 4
) (
    input  logic [2*SLICE_W-1:0] opa,
    input  logic [2*SLICE_W-1:0] opb,
    input  logic                 en,
    output logic                 eq_o,
    output logic                 gt_o,
    output logic                 lt_o
);

    localparam int NSLICE = 2;

    cmp_pkg::cmp_flags_t slice_res [NSLICE];
    cmp_pkg::cmp_flags_t hi_res;
    cmp_pkg::cmp_flags_t lo_res;
    cmp_pkg::cmp_flags_t out_res;

    genvar si;
    generate
        for (si = 0; si < NSLICE; si++) begin : g_slice
            mag_slice #(.W(SLICE_W)) slice_i (
                .a   (opa[si*SLICE_W +: SLICE_W]),
                .b   (opb[si*SLICE_W +: SLICE_W]),
                .res (slice_res[si])
            );
        end
    endgenerate

    assign hi_res = slice_res[1];
    assign lo_res = slice_res[0];

    mag_merge merge_i (
        .hi  (hi_res),
        .lo  (lo_res),
        .en  (en),
        .res (out_res)
    );

    assign eq_o = out_res.eq;
    assign gt_o = out_res.gt;
    assign lt_o = out_res.lt;

endmodule

// File: rtl/mag_cmp8_chk.sv
module mag_cmp8_chk (
    input logic                en,
    input logic                eq_o,
    input logic                gt_o,
    input logic                lt_o,
    input cmp_pkg::cmp_flags_t hi_res,
    input cmp_pkg::cmp_flags_t lo_res
);

    always_comb begin
        AST_EN_LOW_QUIET: assert (en || (!eq_o && !gt_o && !lt_o)); // R6
        AST_ONE_FLAG: assert (!en || ($countones({eq_o, gt_o, lt_o}) == 1)); // R7
        AST_EQ_MATCH: assert (!en || (eq_o == (hi_res.eq && lo_res.eq))); // R3
        AST_HI_DECIDES: assert (!en || hi_res.eq || (gt_o == hi_res.gt && lt_o == hi_res.lt)); // R4
        AST_LO_DECIDES: assert (!en || !hi_res.eq || (gt_o == lo_res.gt && lt_o == lo_res.lt)); // R5
    end

endmodule

bind mag_cmp8 mag_cmp8_chk chk_i (
    .en     (en),
    .eq_o   (eq_o),
    .gt_o   (gt_o),
    .lt_o   (lt_o),
    .hi_res (hi_res),
    .lo_res (lo_res)
);

// File: tb/mag_cmp8_tb_top.sv
`timescale 1ns/1ps
module mag_cmp8_tb_top;

    localparam int SW = 4;
    localparam int DW = 2 * SW;

    logic          clk = 1'b0;
    logic [DW-1:0] opa = '0;
    logic [DW-1:0] opb = '0;
    logic          en  = 1'b0;
    logic          eq_o, gt_o, lt_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    mag_cmp8 #(.SLICE_W(SW)) dut_i (
        .opa  (opa),
        .opb  (opb),
        .en   (en),
        .eq_o (eq_o),
        .gt_o (gt_o),
        .lt_o (lt_o)
    );

    task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s opa=%0d opb=%0d en=%0d actual eq/gt/lt=%b expected=%b",
                     req, opa, opb, en, got, exp);
        end
    endtask

    function automatic logic [2:0] model(input int x, input int y, input logic e);
        if (!e)         return 3'b000;
        else if (x > y) return 3'b010;
        else if (x < y) return 3'b001;
        else            return 3'b100;
    endfunction

    task automatic check_vec();
        logic [2:0] exp;
        logic [2:0] got;
        exp = model(int'(opa), int'(opb), en);
        got = {eq_o, gt_o, lt_o};
        if (!en)              check("R6", got, exp);
        else if (opa > opb)   check("R1", got, exp);
        else if (opa < opb)   check("R2", got, exp);
        else                  check("R3", got, exp);
        if (en) begin
            check("R7", {2'b00, ($countones(got) == 1)}, 3'b001);
            if (opa[DW-1:SW] != opb[DW-1:SW]) check("R4", got, exp);
            else                              check("R5", got, exp);
        end
    endtask

    initial begin : watchdog
        while (cycles < 190000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        // initial state: enable low gives quiet outputs (R6)
        #1;
        check_vec();

        // R8: input changes with no clock edge in between
        en = 1'b1; opa = 8'hA5; opb = 8'h5A; #1;
        check("R8", {eq_o, gt_o, lt_o}, 3'b010);
        opa = 8'h3C; opb = 8'h3D; #1;
        check("R8", {eq_o, gt_o, lt_o}, 3'b001);
        opb = 8'h3C; #1;
        check("R8", {eq_o, gt_o, lt_o}, 3'b100);
        en = 1'b0; #1;
        check("R8", {eq_o, gt_o, lt_o}, 3'b000);

        // exhaustive sweep over both enable values
        for (int e = 0; e < 2; e++) begin
            for (int x = 0; x < (1 << DW); x++) begin
                for (int y = 0; y < (1 << DW); y++) begin
                    @(posedge clk);
                    en  = e[0];
                    opa = x[DW-1:0];
                    opb = y[DW-1:0];
                    @(negedge clk);
                    check_vec();
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule